// File: doc/BRIEF.md
# Affine-Gap Alignment Processing Element

This block is a single cell of a linear systolic array that aligns one streaming database sequence against a stored query, one residue per cell. The cell holds a fixed query residue code. On each valid step it takes a database residue from its left neighbour, together with that neighbour's score and vertical-gap value for the same column, and it evaluates one similarity-matrix cell. The score recurrence uses an open penalty for a new gap and a smaller extend penalty for a continued gap. It then passes the residue and its own results to the right one clock later.

The cell keeps four pieces of state between steps: its previous score, its previous horizontal-gap value, the left neighbour's previous score (the diagonal term) and the query code. Substitution scores come from a programmable 32x32 table of signed bytes. The floor value selects the search mode: a floor of zero gives local alignment, and the most negative floor gives global alignment. A start flag that arrives with the first residue of a sequence replaces the stored history with the row's initial values.

Top module: `align_cell`

## Requirements
- R1: While reset is high and on the first sample after reset, out_valid, out_start, out_char, out_score and out_vgap are all zero.
- R2: out_valid goes high one clock after a step with in_valid high. On that output step, out_char equals the step's in_char and out_start equals the step's in_start.
- R3: On a valid step, out_vgap = max(in_score - cfg_open, in_vgap - cfg_extend), presented one clock later.
- R4: The horizontal gap E = max(Hp - cfg_open, Ep - cfg_extend). Hp and Ep are the score and E the cell produced on its previous valid step.
- R5: On a valid step, out_score = max(cfg_floor, E, F, D + sub). F is the out_vgap of the same step. D is the in_score of the previous valid step. sub is the table entry for the (query, database) pair.
- R6: On a valid step with in_start high, Hp and Ep are both taken as row_init, and D is taken as diag_init.
- R7: Scores are 16-bit two's complement. Every subtraction, and the sum D + sub, saturates at -32768 and +32767 instead of wrapping.
- R8: The table entry for query code q and database code d sits at index q*32 + d. It holds a signed 8-bit value and is written by tbl_we with tbl_addr and tbl_data. A write while in_valid is high is ignored.
- R9: A step with in_valid low drives out_valid low on the next clock. It leaves out_char, out_score, out_vgap and all held history unchanged.
- R10: q_we loads q_data as the query code while in_valid is low. A q_we while in_valid is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_open | input | 16 | Gap-open penalty (signed) |
| cfg_extend | input | 16 | Gap-extend penalty (signed) |
| cfg_floor | input | 16 | Score floor (signed) |
| row_init | input | 16 | Initial score and E of this row (signed) |
| diag_init | input | 16 | Initial score of the row above, used as diagonal at start (signed) |
| q_we | input | 1 | Query code load strobe |
| q_data | input | 5 | Query code to load |
| tbl_we | input | 1 | Substitution table write strobe |
| tbl_addr | input | 10 | Table index, query code times 32 plus database code |
| tbl_data | input | 8 | Table entry value (signed) |
| in_valid | input | 1 | Database residue present this step |
| in_start | input | 1 | First residue of a sequence |
| in_char | input | 5 | Database residue code |
| in_score | input | 16 | Left neighbour score for this column (signed) |
| in_vgap | input | 16 | Left neighbour vertical gap for this column (signed) |
| out_valid | output | 1 | Output step valid |
| out_start | output | 1 | Forwarded start flag |
| out_char | output | 5 | Forwarded residue code |
| out_score | output | 16 | Cell score (signed) |
| out_vgap | output | 16 | Cell vertical gap (signed) |

## Verification
The assertions check on every cycle that residues and flags are forwarded with one step of delay and that idle steps hold the outputs. They also check that the score never drops below the floor or below the vertical gap, and that the vertical gap never drops below the neighbour score minus the open penalty. Only the bench scenarios can show the exact recurrence values: the horizontal gap carried across columns, the restart at the start of a sequence, saturation at both ends, and table and query writes taking effect only when the cell is idle. To show these, the bench sweeps every database code against several query codes in both local and global mode and compares each output with an arithmetic model.

// File: rtl/aln_pkg.sv
package aln_pkg;
    localparam int SCORE_W = 16;
    localparam int RES_W   = 5;
    localparam int SUB_W   = 8;
    localparam int TBL_AW  = 2 * RES_W;

    typedef logic signed [SCORE_W-1:0] score_t;
    typedef logic signed [SCORE_W:0]   wide_t;
    typedef logic [RES_W-1:0]          res_t;
    typedef logic signed [SUB_W-1:0]   sub_t;

    localparam score_t SCORE_MAX = {1'b0, {(SCORE_W-1){1'b1}}};
    localparam score_t SCORE_MIN = {1'b1, {(SCORE_W-1){1'b0}}};

    typedef struct packed {
        logic   valid;
        logic   start;
        res_t   ch;
        score_t score;
        score_t vgap;
    } lane_t;

    typedef struct packed {
        score_t h;
        score_t e;
        score_t diag;
    } hist_t;

    function automatic score_t sat_clip(input wide_t w);
        if (w > $signed({1'b0, SCORE_MAX}))
            return SCORE_MAX;
        else if (w < $signed({1'b1, SCORE_MIN}))
            return SCORE_MIN;
        else
            return w[SCORE_W-1:0];
    endfunction

    function automatic score_t sat_sub(input score_t a, input score_t b);
        wide_t w;
        w = $signed({a[SCORE_W-1], a}) - $signed({b[SCORE_W-1], b});
        return sat_clip(w);
    endfunction

    function automatic score_t sat_add(input score_t a, input score_t b);
        wide_t w;
        w = $signed({a[SCORE_W-1], a}) + $signed({b[SCORE_W-1], b});
        return sat_clip(w);
    endfunction

    function automatic score_t max2(input score_t a, input score_t b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/align_subst_table.sv
module align_subst_table
    import aln_pkg::*;
#(
    parameter int ADDR_W = TBL_AW,
    parameter int DATA_W = SUB_W
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/align_gap_unit.sv
module align_gap_unit
    import aln_pkg::*;
(
    input  score_t h_src,
    input  score_t g_src,
    input  score_t open_pen,
    input  score_t ext_pen,
    output score_t g_out
);
    score_t opened;
    score_t extended;

    always_comb begin
        opened   = sat_sub(h_src, open_pen);
        extended = sat_sub(g_src, ext_pen);
        g_out    = max2(opened, extended);
    end
endmodule

// File: rtl/align_score_unit.sv
module align_score_unit
    import aln_pkg::*;
(
    input  score_t floor_val,
    input  score_t e_val,
    input  score_t f_val,
    input  score_t diag_val,
    input  sub_t   sub_val,
    output score_t h_out
);
    score_t sub_ext;
    score_t diag_sum;
    score_t gap_best;

    always_comb begin
        sub_ext  = score_t'(sub_val);
        diag_sum = sat_add(diag_val, sub_ext);
        gap_best = max2(e_val, f_val);
        h_out    = max2(max2(floor_val, gap_best), diag_sum);
    end
endmodule

// File: rtl/align_cell.sv
module align_cell
    import aln_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic signed [SCORE_W-1:0] cfg_open,
    input  logic signed [SCORE_W-1:0] cfg_extend,
    input  logic signed [SCORE_W-1:0] cfg_floor,
    input  logic signed [SCORE_W-1:0] row_init,
    input  logic signed [SCORE_W-1:0] diag_init,
    input  logic                      q_we,
    input  logic [RES_W-1:0]          q_data,
    input  logic                      tbl_we,
    input  logic [TBL_AW-1:0]         tbl_addr,
    input  logic [SUB_W-1:0]          tbl_data,
    input  logic                      in_valid,
    input  logic                      in_start,
    input  logic [RES_W-1:0]          in_char,
    input  logic signed [SCORE_W-1:0] in_score,
    input  logic signed [SCORE_W-1:0] in_vgap,
    output logic                      out_valid,
    output logic                      out_start,
    output logic [RES_W-1:0]          out_char,
    output logic signed [SCORE_W-1:0] out_score,
    output logic signed [SCORE_W-1:0] out_vgap
);
    localparam int N_GAP = 2;
    localparam int G_VERT = 0;
    localparam int G_HORZ = 1;

    hist_t  hist_q;
    hist_t  hist_sel;
    lane_t  lane_q;
    lane_t  lane_d;
    res_t   query_q;
    logic [SUB_W-1:0] sub_raw;
    score_t gap_h [N_GAP];
    score_t gap_g [N_GAP];
    score_t gap_r [N_GAP];
    score_t h_new;

    // Substitution table: writes only while idle
    align_subst_table #(
        .ADDR_W(TBL_AW),
        .DATA_W(SUB_W)
    ) i_table (
        .clk    (clk),
        .wr_en  (tbl_we && !in_valid),
        .wr_addr(tbl_addr),
        .wr_data(tbl_data),
        .rd_addr({query_q, in_char}),
        .rd_data(sub_raw)
    );

    // History used this step: stored values or row start values
    always_comb begin
        if (in_start) begin
            hist_sel.h    = row_init;
            hist_sel.e    = row_init;
            hist_sel.diag = diag_init;
        end else begin
            hist_sel = hist_q;
        end
    end

    always_comb begin
        gap_h[G_VERT] = in_score;
        gap_g[G_VERT] = in_vgap;
        gap_h[G_HORZ] = hist_sel.h;
        gap_g[G_HORZ] = hist_sel.e;
    end

    // Two identical gap recurrences: vertical from the neighbour, horizontal from own history
    for (genvar g = 0; g < N_GAP; g++) begin : g_gap
        align_gap_unit i_gap (
            .h_src   (gap_h[g]),
            .g_src   (gap_g[g]),
            .open_pen(cfg_open),
            .ext_pen (cfg_extend),
            .g_out   (gap_r[g])
        );
    end

    align_score_unit i_score (
        .floor_val(cfg_floor),
        .e_val    (gap_r[G_HORZ]),
        .f_val    (gap_r[G_VERT]),
        .diag_val (hist_sel.diag),
        .sub_val  (sub_t'(sub_raw)),
        .h_out    (h_new)
    );

    always_comb begin
        lane_d       = lane_q;
        lane_d.valid = in_valid;
        if (in_valid) begin
            lane_d.start = in_start;
            lane_d.ch    = in_char;
            lane_d.score = h_new;
            lane_d.vgap  = gap_r[G_VERT];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lane_q  <= '0;
            hist_q  <= '0;
            query_q <= '0;
        end else begin
            lane_q <= lane_d;
            if (in_valid) begin
                hist_q.h    <= h_new;
                hist_q.e    <= gap_r[G_HORZ];
                hist_q.diag <= in_score;
            end else if (q_we) begin
                query_q <= q_data;
            end
        end
    end

    assign out_valid = lane_q.valid;
    assign out_start = lane_q.start;
    assign out_char  = lane_q.ch;
    assign out_score = lane_q.score;
    assign out_vgap  = lane_q.vgap;
endmodule

// File: rtl/align_cell_chk.sv
module align_cell_chk
    import aln_pkg::*;
(
    input logic                      clk,
    input logic                      rst,
    input logic signed [SCORE_W-1:0] cfg_open,
    input logic signed [SCORE_W-1:0] cfg_floor,
    input logic                      in_valid,
    input logic                      in_start,
    input logic [RES_W-1:0]          in_char,
    input logic signed [SCORE_W-1:0] in_score,
    input logic                      out_valid,
    input logic                      out_start,
    input logic [RES_W-1:0]          out_char,
    input logic signed [SCORE_W-1:0] out_score,
    input logic signed [SCORE_W-1:0] out_vgap
);
    p_forward_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_valid && out_char == $past(in_char) && out_start == $past(in_start)));

    p_vgap_bound_r3: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_vgap >= sat_sub($past(in_score), $past(cfg_open))));

    p_floor_r5: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_score >= $past(cfg_floor)));

    p_score_covers_vgap_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_score >= out_vgap));

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_score) && $stable(out_vgap) && $stable(out_char)));
endmodule

bind align_cell align_cell_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_open (cfg_open),
    .cfg_floor(cfg_floor),
    .in_valid (in_valid),
    .in_start (in_start),
    .in_char  (in_char),
    .in_score (in_score),
    .out_valid(out_valid),
    .out_start(out_start),
    .out_char (out_char),
    .out_score(out_score),
    .out_vgap (out_vgap)
);

// File: tb/test_align_cell.sv
`timescale 1ns/100ps
module test_align_cell;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic signed [15:0] cfg_open = 16'sd10, cfg_extend = 16'sd2, cfg_floor = 16'sd0;
    logic signed [15:0] row_init = 16'sd0, diag_init = 16'sd0;
    logic q_we = 1'b0;
    logic [4:0] q_data = '0;
    logic tbl_we = 1'b0;
    logic [9:0] tbl_addr = '0;
    logic [7:0] tbl_data = '0;
    logic in_valid = 1'b0, in_start = 1'b0;
    logic [4:0] in_char = '0;
    logic signed [15:0] in_score = '0, in_vgap = '0;
    logic out_valid, out_start;
    logic [4:0] out_char;
    logic signed [15:0] out_score, out_vgap;

    always #2.5 clk = ~clk;

    align_cell i_align_cell (.*);

    int n_checks = 0, n_err = 0;
    int m_tbl [1024];
    int m_q = 0, m_h = 0, m_e = 0, m_d = 0;
    int x_valid = 0, x_start = 0, x_char = 0, x_h = 0, x_f = 0;
    int lfsr = 32'h1234;
    bit done = 0;

    function automatic int clampv(input int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
    function automatic int tbl_fn(input int q, input int d);
        return (q == d) ? 6 : -((q * 3 + d) % 5);
    endfunction

    function automatic int rnd(input int span, input int base);
        lfsr = (lfsr * 1103515245 + 12345) & 32'h7fffffff;
        return ((lfsr >>> 8) % span) + base;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic load_tbl(input int idx, input int val);
        tbl_we = 1'b1; tbl_addr = idx[9:0]; tbl_data = val[7:0];
        @(negedge clk);
        tbl_we = 1'b0;
        m_tbl[idx] = val;
    endtask

    task automatic load_query(input int q);
        q_we = 1'b1; q_data = q[4:0];
        @(negedge clk);
        q_we = 1'b0;
        m_q = q;
    endtask

    task automatic run_step(input bit v, input bit st, input int ch, input int sc,
                            input int vg, input string tag);
        int ph, pe, dg, f, e, h;
        in_valid = v; in_start = st; in_char = ch[4:0];
        in_score = sc[15:0]; in_vgap = vg[15:0];
        if (v) begin
            ph = st ? int'(row_init) : m_h;
            pe = st ? int'(row_init) : m_e;
            dg = st ? int'(diag_init) : m_d;
            f = mx(clampv(sc - int'(cfg_open)), clampv(vg - int'(cfg_extend)));
            e = mx(clampv(ph - int'(cfg_open)), clampv(pe - int'(cfg_extend)));
            h = mx(mx(int'(cfg_floor), e), mx(f, clampv(dg + m_tbl[m_q * 32 + ch])));
            m_h = h; m_e = e; m_d = sc;
            x_valid = 1; x_start = st; x_char = ch; x_h = h; x_f = f;
        end else begin
            x_valid = 0;
        end
        @(negedge clk);
        tbl_we = 1'b0; q_we = 1'b0; in_valid = 1'b0; in_start = 1'b0;
        chk(v ? "R2" : "R9", int'(out_valid), x_valid);
        chk(v ? "R2" : "R9", int'(out_char), x_char);
        chk(v ? "R2" : "R9", int'(out_start), x_start);
        chk(v ? "R3" : "R9", int'(out_vgap), x_f);
        chk(tag, int'(out_score), x_h);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", int'(out_valid), 0);
        chk("R1", int'(out_score), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", int'(out_valid), 0);
        chk("R1", int'(out_start), 0);
        chk("R1", int'(out_char), 0);
        chk("R1", int'(out_score), 0);
        chk("R1", int'(out_vgap), 0);

        for (int i = 0; i < 1024; i++) load_tbl(i, tbl_fn(i / 32, i % 32));

        // Local mode: all database codes against several query codes
        for (int k = 0; k < 4; k++) begin
            load_query((k * 11 + 2) % 32);
            for (int d = 0; d < 32; d++) begin
                if (d % 6 == 5) run_step(0, 0, 0, 0, 0, "R9");
                run_step(1, d == 0, d, rnd(200, -50), rnd(200, -60), d == 0 ? "R6" : "R5");
            end
        end

        // Global mode: horizontal gap carried across columns, restart mid-stream
        cfg_floor = -16'sd32768; cfg_open = 16'sd7; cfg_extend = 16'sd1;
        row_init = -16'sd40; diag_init = -16'sd25;
        load_query(12);
        for (int k = 0; k < 40; k++)
            run_step(1, (k == 0) || (k == 20), (k * 7) % 32, rnd(300, -300), rnd(300, -320),
                     ((k == 0) || (k == 20)) ? "R6" : "R4");

        // Saturation at both limits
        load_tbl(31 * 32 + 31, 127);
        load_query(31);
        cfg_open = 16'sd100; cfg_extend = 16'sd5;
        row_init = -16'sd32768; diag_init = 16'sd32700;
        run_step(1, 1, 31, 32700, 0, "R7");
        run_step(1, 0, 31, -32760, -32768, "R7");
        run_step(1, 0, 5, -32768, -32768, "R7");
        chk("R7", int'(out_vgap), -32768);

        // Table writes: idle write lands, write during a valid step is ignored
        cfg_open = 16'sd10; cfg_extend = 16'sd2;
        row_init = -16'sd200; diag_init = 16'sd0;
        load_query(3);
        load_tbl(3 * 32 + 9, 50);
        run_step(1, 1, 9, -200, -200, "R8");
        chk("R8", int'(out_score), 50);
        tbl_we = 1'b1; tbl_addr = 10'(3 * 32 + 10); tbl_data = 8'd100;
        run_step(1, 0, 4, -200, -200, "R8");
        run_step(1, 0, 10, 0, -200, "R8");

        // Query load ignored while valid, taken while idle
        q_we = 1'b1; q_data = 5'd20;
        run_step(1, 1, 3, 0, -200, "R10");
        run_step(1, 0, 3, 0, -200, "R10");
        load_query(20);
        run_step(1, 1, 20, 0, -200, "R10");
        run_step(0, 0, 0, 0, 0, "R9");

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule